// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Transfer Engine

This block moves a programmed number of words between one I/O device data port and system memory without the processor copying each word. Software loads a base address, a word count and a direction through a small register port, then sets a go bit. The engine raises a bus request and waits for the grant. It does not touch the memory or the device until the grant arrives.

Each word takes two bus accesses. The first reads the word from the source, and the second writes it to the destination. Both sides use the same handshake: valid is held with stable address and data until the target answers with ready. After each word the memory address steps by one and the remaining count drops by one. When the count reaches zero the request is released, so that the processor can take the grant back. A status register then reports completion.

If the grant is withdrawn in the middle of a word, that word still completes. The engine then drops its request for a cycle and asks again. A go with a count of zero reports completion at once and never requests the bus.

Top module: `dma_engine`

## Requirements
- R1: Register offsets on `cfg_addr` are 0 = base address, 1 = word count and 2 = control/status. A write to offset 0 or 1 is read back unchanged through `cfg_rdata`. In the status word, bit 0 is busy, bit 1 is done and bit 2 is direction. On a write to offset 2, bit 0 starts a transfer, bit 1 clears done and bit 2 sets the direction.
- R2: After reset, `bus_req`, `mem_valid` and `dev_valid` are low and the status word reads zero.
- R3: A go with a non-zero count raises `bus_req` in the cycle after the write. No memory or device access begins unless the grant was high at the clock edge where the access starts.
- R4: With direction 0, each word is read from the device and written to memory, at consecutive addresses starting at the base.
- R5: With direction 1, words are read from memory at consecutive addresses starting at the base and written to the device in the same order.
- R6: The address steps by one and the count drops by one for every completed word. After the last word, `bus_req` is low in the next cycle. In that same cycle busy reads 0 and done reads 1.
- R7: A go with a count of zero sets done in the next cycle, and `bus_req` stays low.
- R8: While busy, writes to the base address, the count and the direction are ignored, and a go has no effect.
- R9: Writing 1 to status bit 1 clears done. Writing 0 there leaves done unchanged.
- R10: If the grant falls while a word is in flight, that word completes and `bus_req` then drops for at least one cycle. The engine re-requests the bus, starts no word without the grant, and still transfers every word.
- R11: An access whose ready is low keeps its valid, write enable, address and write data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset for both read and write |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_addr` (combinational) |
| bus_req | output | 1 | Request for ownership of the system bus |
| bus_gnt | input | 1 | Grant of the system bus from the processor |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory completes the access this cycle |
| dev_valid | output | 1 | Device access valid |
| dev_we | output | 1 | Device access is a write |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | DATA_W | Device read data, valid with ready |
| dev_ready | input | 1 | Device completes the access this cycle |

## Verification
The transfer path runs in both directions, in three patterns.

- Targets that are always ready show the minimum two-cycle word rhythm.
- Targets that stall on staggered cycles show whether the held access stays put.
- A grant taken away mid-run separates a design that pauses at a word boundary from one that keeps running without the bus.

A delayed grant shows whether any access starts before ownership. Zero-length and busy-time register writes check that the control path cannot start or change a transfer it should not.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        XS_IDLE  = 3'd0,
        XS_REQ   = 3'd1,
        XS_SRC   = 3'd2,
        XS_DST   = 3'd3,
        XS_PAUSE = 3'd4
    } xfer_state_e;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_COUNT = 2'd1;
    localparam logic [1:0] REG_CSR   = 2'd2;

    localparam int CSR_GO_BUSY = 0;
    localparam int CSR_DONE    = 1;
    localparam int CSR_DIR     = 2;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy_i,
    input  logic              finish_i,
    output logic              start_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  count_o,
    output logic              dir_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [LEN_W-1:0]  count;
        logic              dir;
        logic              done;
    } regs_t;

    regs_t q, d;
    logic  csr_wr;
    logic  zero_go;
    logic  unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        d       = q;
        start_o = 1'b0;
        zero_go = 1'b0;
        csr_wr  = cfg_wr && (cfg_addr == REG_CSR);
        if (cfg_wr && (cfg_addr == REG_BASE) && !busy_i)
            d.base = cfg_wdata[ADDR_W-1:0];
        if (cfg_wr && (cfg_addr == REG_COUNT) && !busy_i)
            d.count = cfg_wdata[LEN_W-1:0];
        if (csr_wr && !busy_i) begin
            d.dir = cfg_wdata[CSR_DIR];
            if (cfg_wdata[CSR_GO_BUSY]) begin
                if (q.count == '0) zero_go = 1'b1;
                else               start_o = 1'b1;
            end
        end
        if (csr_wr && cfg_wdata[CSR_DONE]) d.done = 1'b0;
        if (finish_i || zero_go)           d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base_o  = q.base;
    assign count_o = q.count;
    assign dir_o   = d.dir;

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_BASE:  cfg_rdata = DATA_W'(q.base);
            REG_COUNT: cfg_rdata = DATA_W'(q.count);
            REG_CSR: begin
                cfg_rdata[CSR_GO_BUSY] = busy_i;
                cfg_rdata[CSR_DONE]    = q.done;
                cfg_rdata[CSR_DIR]     = q.dir;
            end
            default: cfg_rdata = '0;
        endcase
    end

    assert_base_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cfg_wr && cfg_addr == REG_BASE) |=> $stable(q.base));

    assert_count_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cfg_wr && cfg_addr == REG_COUNT) |=> $stable(q.count));

    assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == REG_CSR && cfg_wdata[CSR_DONE]
         && !cfg_wdata[CSR_GO_BUSY] && !finish_i) |=> !q.done);

    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == REG_CSR && cfg_wdata[CSR_GO_BUSY]
         && !busy_i && q.count == '0) |=> (q.done && !busy_i));

endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [LEN_W-1:0]  start_len_i,
    input  logic              start_dir_i,
    output logic              busy_o,
    output logic              finish_o,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              dev_valid,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ready
);

    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        logic              dir;
        logic [DATA_W-1:0] hold;
    } xs_t;

    xs_t q, d;
    logic              src_ready;
    logic              dst_ready;
    logic [DATA_W-1:0] src_data;
    logic              in_src;
    logic              in_dst;

    always_comb begin
        d         = q;
        finish_o  = 1'b0;
        src_ready = q.dir ? mem_ready : dev_ready;
        dst_ready = q.dir ? dev_ready : mem_ready;
        src_data  = q.dir ? mem_rdata : dev_rdata;
        case (q.st)
            XS_IDLE: begin
                if (start_i) begin
                    d.st   = XS_REQ;
                    d.addr = start_addr_i;
                    d.left = start_len_i;
                    d.dir  = start_dir_i;
                end
            end
            XS_REQ: begin
                if (bus_gnt) d.st = XS_SRC;
            end
            XS_SRC: begin
                if (src_ready) begin
                    d.hold = src_data;
                    d.st   = XS_DST;
                end
            end
            XS_DST: begin
                if (dst_ready) begin
                    d.addr = q.addr + 1'b1;
                    d.left = q.left - 1'b1;
                    if (q.left == LEN_W'(1)) begin
                        finish_o = 1'b1;
                        d.st     = XS_IDLE;
                    end else if (!bus_gnt) begin
                        d.st = XS_PAUSE;
                    end else begin
                        d.st = XS_SRC;
                    end
                end
            end
            XS_PAUSE: d.st = XS_REQ;
            default:  d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_src    = (q.st == XS_SRC);
    assign in_dst    = (q.st == XS_DST);
    assign busy_o    = (q.st != XS_IDLE);
    assign bus_req   = (q.st == XS_REQ) || in_src || in_dst;
    assign mem_valid = (in_src && q.dir) || (in_dst && !q.dir);
    assign mem_we    = in_dst && !q.dir;
    assign dev_valid = (in_src && !q.dir) || (in_dst && q.dir);
    assign dev_we    = in_dst && q.dir;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.hold;
    assign dev_wdata = q.hold;

    assert_grant_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid || dev_valid) |-> $past(bus_gnt));

    assert_nonzero_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |-> (start_len_i != '0));

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dst && dst_ready) |=> (q.addr == $past(q.addr) + 1'b1)
                                  && (q.left == $past(q.left) - 1'b1));

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> (!bus_req && !busy_o));

    assert_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_dst && dst_ready && !bus_gnt && !finish_o) |=> !bus_req);

    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_we) && $stable(mem_wdata)));

    assert_dev_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_we)
                                       && $stable(dev_wdata)));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              dev_valid,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ready
);

    logic              busy;
    logic              finish;
    logic              start;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  count;
    logic              dir;

    dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .busy_i   (busy),
        .finish_i (finish),
        .start_o  (start),
        .base_o   (base),
        .count_o  (count),
        .dir_o    (dir)
    );

    dma_xfer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .start_addr_i(base),
        .start_len_i (count),
        .start_dir_i (dir),
        .busy_o      (busy),
        .finish_o    (finish),
        .bus_req     (bus_req),
        .bus_gnt     (bus_gnt),
        .mem_valid   (mem_valid),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .mem_ready   (mem_ready),
        .dev_valid   (dev_valid),
        .dev_we      (dev_we),
        .dev_wdata   (dev_wdata),
        .dev_rdata   (dev_rdata),
        .dev_ready   (dev_ready)
    );

endmodule

// File: tb/test_dma_engine.sv
`timescale 1ns/1ps
module test_dma_engine;

    localparam int AW = 16;
    localparam int LW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic          mem_valid, mem_we, dev_valid, dev_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
    logic          mem_ready = 1'b0;
    logic          dev_ready = 1'b0;

    int nchk = 0;
    int nfail = 0;

    logic [DW-1:0] bmem [0:255];
    int src_idx = 0;
    bit pend_src = 0;

    // reference model state
    bit model_active = 0;
    int exp_addr = 0;
    int exp_left = 0;
    int exp_src = 0;
    int last_rd = 0;
    bit chk_release = 0;
    bit prev_act = 0;
    bit gnt_prev = 0;
    bit prev_mstall = 0;
    logic [AW-1:0] prev_maddr = '0;
    int rmode = 0;
    int cyc_cnt = 0;

    always #2 clk = ~clk;

    assign mem_rdata = bmem[mem_addr[7:0]];
    assign dev_rdata = 32'hA500_0000 + DW'(src_idx);

    dma_engine #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW)) i_dma_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .dev_valid(dev_valid), .dev_we(dev_we), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_ready(dev_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ready pattern driver
    always @(negedge clk) begin
        cyc_cnt++;
        mem_ready <= (rmode == 0) || (cyc_cnt % 3 == 0);
        dev_ready <= (rmode == 0) || (cyc_cnt % 3 == 1);
    end

    // cycle monitor and reference model
    always @(negedge clk) begin
        if (pend_src) begin
            src_idx  = src_idx + 1;
            pend_src = 0;
        end
        #1;
        if (rst_n) begin
            if (chk_release) begin
                chk(!bus_req, "R6", "request after last word", 64'(bus_req), 64'd0);
                chk_release  = 0;
                model_active = 0;
            end
            if ((mem_valid || dev_valid) && !prev_act) begin
                chk(gnt_prev, "R3", "access start without grant", 64'(gnt_prev), 64'd1);
                chk(model_active, "R3", "access with no transfer", 64'(model_active), 64'd1);
            end
            if (prev_mstall) begin
                chk(mem_valid && mem_addr == prev_maddr, "R11", "stalled memory access moved",
                    64'(mem_addr), 64'(prev_maddr));
            end
            if (dev_valid && dev_ready) begin
                if (!dev_we) begin
                    pend_src = 1;
                end else begin
                    chk(dev_wdata == 32'hC0DE_0000 + DW'(last_rd), "R5", "device write data",
                        64'(dev_wdata), 64'(32'hC0DE_0000 + DW'(last_rd)));
                    exp_addr++;
                    exp_left--;
                    if (exp_left == 0) chk_release = 1;
                end
            end
            if (mem_valid && mem_ready) begin
                chk(int'(mem_addr) == exp_addr, "R6", "memory address", 64'(mem_addr), 64'(exp_addr));
                if (mem_we) begin
                    chk(mem_wdata == 32'hA500_0000 + DW'(exp_src), "R4", "memory write data",
                        64'(mem_wdata), 64'(32'hA500_0000 + DW'(exp_src)));
                    bmem[mem_addr[7:0]] = mem_wdata;
                    exp_src++;
                    exp_addr++;
                    exp_left--;
                    if (exp_left == 0) chk_release = 1;
                end else begin
                    last_rd = int'(mem_addr);
                end
            end
            prev_act    = mem_valid || dev_valid;
            prev_mstall = mem_valid && !mem_ready;
            prev_maddr  = mem_addr;
        end
        gnt_prev = bus_gnt;
    end

    task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [DW-1:0] v);
        cfg_addr = a;
        #0.5;
        v = cfg_rdata;
    endtask

    task automatic arm(input int base, input int len);
        exp_addr = base;
        exp_left = len;
        exp_src = src_idx;
        model_active = 1;
    endtask

    task automatic grant_loop(input int delay, input int steal_at, input int steal_len,
                              output bit saw_drop);
        int dcount = 0;
        int hold = 0;
        bit finished = 0;
        saw_drop = 0;
        for (int cyc = 1; cyc < 600; cyc++) begin
            @(negedge clk);
            if (steal_at > 0 && cyc == steal_at) begin
                bus_gnt = 1'b0;
                hold = steal_len;
            end else if (hold > 0) begin
                hold--;
                if (!bus_req) saw_drop = 1;
            end else if (bus_req && !bus_gnt) begin
                dcount++;
                if (dcount >= delay) begin
                    bus_gnt = 1'b1;
                    dcount = 0;
                end
            end else if (!bus_req && bus_gnt) begin
                bus_gnt = 1'b0;
            end
            if (!model_active && !bus_req && !bus_gnt) begin
                finished = 1;
                break;
            end
        end
        chk(finished, "R6", "transfer finished", 64'(finished), 64'd1);
        chk(exp_left == 0, "R6", "words left", 64'(exp_left), 64'd0);
    endtask

    initial begin
        #(4 * 100000);
        chk(0, "R6", "watchdog expired", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        bit drop;
        for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 + DW'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        peek(2'd2, v);
        chk(v == 0, "R2", "status after reset", 64'(v), 64'd0);
        chk(!bus_req, "R2", "request after reset", 64'(bus_req), 64'd0);
        chk(!mem_valid && !dev_valid, "R2", "access after reset",
            64'({mem_valid, dev_valid}), 64'd0);

        // R1 register readback
        cfg_write(2'd0, 32'h0000_0010);
        cfg_write(2'd1, 32'h0000_0004);
        peek(2'd0, v);
        chk(v == 32'h10, "R1", "base readback", 64'(v), 64'h10);
        peek(2'd1, v);
        chk(v == 32'h4, "R1", "count readback", 64'(v), 64'h4);

        // R7 zero length
        cfg_write(2'd1, 32'h0);
        cfg_write(2'd2, 32'h1);
        peek(2'd2, v);
        chk(v[1:0] == 2'b10, "R7", "status after zero go", 64'(v[1:0]), 64'b10);
        repeat (3) begin
            @(negedge clk);
            #0.5;
            chk(!bus_req, "R7", "request after zero go", 64'(bus_req), 64'd0);
        end

        // R9 done clear
        cfg_write(2'd2, 32'h0);
        peek(2'd2, v);
        chk(v[1] == 1'b1, "R9", "done after writing 0", 64'(v[1]), 64'd1);
        cfg_write(2'd2, 32'h2);
        peek(2'd2, v);
        chk(v[1] == 1'b0, "R9", "done after writing 1", 64'(v[1]), 64'd0);

        // R3 R4 device to memory, delayed grant, always ready
        rmode = 0;
        cfg_write(2'd1, 32'h4);
        arm(32'h10, 4);
        cfg_write(2'd2, 32'h1);
        #0.5;
        chk(bus_req, "R3", "request after go", 64'(bus_req), 64'd1);
        grant_loop(3, 0, 0, drop);
        peek(2'd2, v);
        chk(v[1:0] == 2'b10, "R6", "status after finish", 64'(v[1:0]), 64'b10);
        cfg_write(2'd2, 32'h2);

        // R5 R8 R11 memory to device with stalls and busy-time writes
        rmode = 1;
        cfg_write(2'd0, 32'h40);
        cfg_write(2'd1, 32'h5);
        arm(32'h40, 5);
        cfg_write(2'd2, 32'h5);
        fork
            grant_loop(1, 0, 0, drop);
            begin
                repeat (2) @(negedge clk);
                cfg_write(2'd0, 32'h99);
                cfg_write(2'd1, 32'h7);
                cfg_write(2'd2, 32'h1);
                peek(2'd0, v);
                chk(v == 32'h40, "R8", "base written while busy", 64'(v), 64'h40);
                peek(2'd1, v);
                chk(v == 32'h5, "R8", "count written while busy", 64'(v), 64'h5);
                peek(2'd2, v);
                chk(v[2] == 1'b1, "R8", "direction written while busy", 64'(v[2]), 64'd1);
            end
        join
        peek(2'd2, v);
        chk(v[2:0] == 3'b110, "R6", "status after memory to device", 64'(v[2:0]), 64'b110);
        repeat (3) @(negedge clk);
        #0.5;
        chk(!bus_req, "R8", "go while busy started a transfer", 64'(bus_req), 64'd0);
        cfg_write(2'd2, 32'h2);

        // R10 grant withdrawn mid transfer
        rmode = 0;
        cfg_write(2'd0, 32'h80);
        cfg_write(2'd1, 32'h6);
        arm(32'h80, 6);
        cfg_write(2'd2, 32'h1);
        grant_loop(2, 8, 4, drop);
        chk(drop, "R10", "request dropped after grant loss", 64'(drop), 64'd1);
        peek(2'd2, v);
        chk(v[1:0] == 2'b10, "R10", "status after resumed transfer", 64'(v[1:0]), 64'b10);
        for (int i = 0; i < 6; i++) begin
            chk(bmem[8'h80 + i] == 32'hA500_0000 + DW'(src_idx - 6 + i), "R4",
                "memory contents after pause", 64'(bmem[8'h80 + i]),
                64'(32'hA500_0000 + DW'(src_idx - 6 + i)));
        end

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule